// File: doc/BRIEF.md
# Non-volatile memory programming command sequencer

This block turns high-level programming requests into the byte sequences that a two-wire programming byte link carries to a target memory controller. A request selects one of seven operations: open a session, read a run of bytes from a 32-bit address, load the page buffer, commit a page, write a fuse, poll the busy flag, or close the session. The sequencer asks the link layer for one operation at a time: send a byte, receive a byte, run the link entry procedure, or park the lines. It streams received data out, pulls payload bytes in, and reports a 3-bit error code and a transfer count when the request completes.

The flash and EEPROM regions are selected by the request itself (the `req_eeprom` flag for load and commit). The commit command for flash depends on where the page lies relative to a boot section base supplied on a static input. Two bounded polling loops exist. One waits for the controller to come up after the unlock key. The other waits for the controller's busy flag to clear after a commit or a fuse write. Each loop ends in its own error code when its limit runs out.

Top module: `nvm_seq`

## Requirements
- R1: After reset `busy`, `done`, `lnk_req`, `wr_ready`, `rd_valid`, `err_code` and `xfer_cnt` are all 0. While `busy` is 0 no link operation is requested.
- R2: Open (kind 0) requests link entry (op 2). It then sends C1 59 E0 FF 88 D8 CD 45 AB 89 12, followed by attempts made of a send of 80 and a receive (op 1). The attempts repeat until a received byte has bit 1 set, and the request then ends with error 0.
- R3: If OPEN_TRIES open attempts all return bit 1 clear, open ends with error 2 (controller timeout) after exactly OPEN_TRIES attempts.
- R4: A controller register write is sent as 4C, CA (command register), 01, 00, 01, then the value. Every read, load, commit and fuse request starts with one such write.
- R5: Read (kind 1) writes command 43. It then sends 6B, the four address bytes least significant first, A0, length minus 1 and 24. After that it receives length bytes, presents each one on `rd_data` with a one-cycle `rd_valid`, and reports the count in `xfer_cnt`.
- R6: A receive that returns with `lnk_rerr` set ends any request at once with error 1 (link read error). A read stops early, and `xfer_cnt` holds the number of good bytes received. Completed requests report only codes 0, 1, 2 and 5.
- R7: Load (kind 2) writes command 23 for flash or 33 for EEPROM. It uses the same pointer and repeat preamble with opcode 64, then sends the length payload bytes taken from `wr_data` in order.
- R8: Commit (kind 3) writes command 35 for EEPROM. For flash it writes 25 when address bits 23:16 are below `boot_base`, and 2D otherwise.
- R9: After its command, commit sends 4C, the four address bytes least significant first and 00. It then polls status with 0C CF 01 00 01 followed by a receive, repeating while bit 7 of the status is set, and ends with error 0 when bit 7 reads clear. Poll (kind 5) runs only this status loop.
- R10: If BUSY_TRIES status polls all return bit 7 set, the request ends with error 5 (busy).
- R11: Fuse write (kind 4) writes command 4C. It then sends 4C, 20 OR index, 00, 8F, 00, the value, and busy-polls as in R9.
- R12: Close (kind 6) sends C1 00. It then writes 00 to the command register and requests a line park (op 3), which leaves data low and clock high.
- R13: A read or load of length 0, or kind 7, completes in the cycle after acceptance with error 0, `xfer_cnt` 0 and no link operation.
- R14: A requested link operation keeps its op and byte steady until `lnk_done`. A request presented while `busy` is 1 is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request strobe, taken when busy is 0 |
| req_kind | input | 3 | 0 open, 1 read, 2 load, 3 commit, 4 fuse, 5 poll, 6 close, 7 none |
| req_addr | input | 32 | Target address for read, load and commit |
| req_len | input | LEN_W | Byte count for read and load |
| req_eeprom | input | 1 | 1 selects EEPROM, 0 flash (load and commit) |
| req_fuse_idx | input | 3 | Fuse index |
| req_value | input | 8 | Fuse value |
| boot_base | input | 8 | Boot section base, compared with address bits 23:16 |
| busy | output | 1 | Request in progress |
| done | output | 1 | One-cycle completion pulse |
| err_code | output | 3 | Result of the last request |
| xfer_cnt | output | LEN_W | Bytes moved by the last read or load |
| wr_data | input | 8 | Payload byte for load |
| wr_valid | input | 1 | Payload byte available |
| wr_ready | output | 1 | Payload byte taken this cycle |
| rd_data | output | 8 | Received read byte |
| rd_valid | output | 1 | rd_data valid for one cycle |
| lnk_req | output | 1 | Link operation requested |
| lnk_op | output | 2 | 0 send, 1 receive, 2 entry, 3 park |
| lnk_byte | output | 8 | Byte to send |
| lnk_done | input | 1 | Link operation finished (one cycle) |
| lnk_rdata | input | 8 | Byte received by the link |
| lnk_rerr | input | 1 | Receive failed (framing or parity) |

## Verification
The open request is driven with status bytes that raise bit 1 only on the third attempt, and with bytes that never raise it. Comparing the two shows that the retry loop follows bit 1 alone and stops at the limit. Commits use addresses just below and at the boot base, plus EEPROM, to show that each of the three command codes is chosen. Status streams with bit 7 held for a few polls, and then forever, show the difference between a slow finish and a busy timeout. Reads with and without a failed receive in the middle show that counting stops early, and zero-length requests show that no link traffic occurs at all.

// File: rtl/nvm_seq_pkg.sv
package nvm_seq_pkg;

  typedef enum logic [1:0] {LOP_SEND = 2'd0, LOP_RECV = 2'd1, LOP_ENTER = 2'd2, LOP_PARK = 2'd3} lop_e;

  typedef enum logic [2:0] {
    RK_OPEN = 3'd0, RK_READ = 3'd1, RK_LOAD = 3'd2, RK_COMMIT = 3'd3,
    RK_FUSE = 3'd4, RK_POLL = 3'd5, RK_CLOSE = 3'd6, RK_NONE = 3'd7
  } rkind_e;

  typedef enum logic [3:0] {
    PH_IDLE, PH_ENTER, PH_UNLOCK, PH_ARM, PH_REGW, PH_PTR,
    PH_XFER, PH_DIRW, PH_POLL, PH_CLOSE, PH_PARK
  } phase_e;

  localparam logic [2:0] ERR_NONE    = 3'd0;
  localparam logic [2:0] ERR_LINK    = 3'd1;
  localparam logic [2:0] ERR_TIMEOUT = 3'd2;
  localparam logic [2:0] ERR_BUSY    = 3'd5;

  localparam logic [7:0] CMD_REG  = 8'hCA;
  localparam logic [7:0] STAT_REG = 8'hCF;

  function automatic logic [7:0] load_cmd(logic eep);
    return eep ? 8'h33 : 8'h23;
  endfunction

  function automatic logic [7:0] commit_cmd(logic eep, logic [31:0] a, logic [7:0] boot);
    if (eep) return 8'h35;
    return (a[23:16] < boot) ? 8'h25 : 8'h2D;
  endfunction

  function automatic logic [7:0] unlock_byte(logic [3:0] st);
    case (st)
      4'd0: return 8'hC1;  4'd1: return 8'h59;  4'd2: return 8'hE0;
      4'd3: return 8'hFF;  4'd4: return 8'h88;  4'd5: return 8'hD8;
      4'd6: return 8'hCD;  4'd7: return 8'h45;  4'd8: return 8'hAB;
      4'd9: return 8'h89;  default: return 8'h12;
    endcase
  endfunction

  function automatic logic [3:0] phase_last(phase_e ph);
    case (ph)
      PH_UNLOCK: return 4'd10;
      PH_ARM, PH_CLOSE: return 4'd1;
      PH_REGW, PH_DIRW, PH_POLL: return 4'd5;
      PH_PTR: return 4'd7;
      default: return 4'd0;
    endcase
  endfunction

  function automatic phase_e first_phase(rkind_e k);
    case (k)
      RK_OPEN: return PH_ENTER;
      RK_POLL: return PH_POLL;
      RK_CLOSE: return PH_CLOSE;
      RK_NONE: return PH_IDLE;
      default: return PH_REGW;
    endcase
  endfunction

  function automatic phase_e next_phase(rkind_e k, phase_e ph);
    case (ph)
      PH_ENTER: return PH_UNLOCK;
      PH_UNLOCK: return PH_ARM;
      PH_REGW: begin
        if (k == RK_CLOSE) return PH_PARK;
        if (k == RK_READ || k == RK_LOAD) return PH_PTR;
        return PH_DIRW;
      end
      PH_PTR: return PH_XFER;
      PH_DIRW: return PH_POLL;
      PH_CLOSE: return PH_REGW;
      default: return PH_IDLE;
    endcase
  endfunction

  function automatic lop_e frame_op(phase_e ph, logic [3:0] st, rkind_e k);
    case (ph)
      PH_ENTER: return LOP_ENTER;
      PH_PARK: return LOP_PARK;
      PH_ARM: return (st == 4'd1) ? LOP_RECV : LOP_SEND;
      PH_POLL: return (st == 4'd5) ? LOP_RECV : LOP_SEND;
      PH_XFER: return (k == RK_READ) ? LOP_RECV : LOP_SEND;
      default: return LOP_SEND;
    endcase
  endfunction

  function automatic logic [7:0] frame_byte(phase_e ph, logic [3:0] st, rkind_e k,
      logic [31:0] a, logic [7:0] len, logic [7:0] rv, logic [31:0] da,
      logic [7:0] dd, logic [7:0] hold);
    case (ph)
      PH_UNLOCK: return unlock_byte(st);
      PH_ARM: return (st == 4'd0) ? 8'h80 : 8'h00;
      PH_REGW, PH_POLL: begin
        case (st)
          4'd0: return (ph == PH_REGW) ? 8'h4C : 8'h0C;
          4'd1: return (ph == PH_REGW) ? CMD_REG : STAT_REG;
          4'd2, 4'd4: return 8'h01;
          4'd3: return 8'h00;
          default: return (ph == PH_REGW) ? rv : 8'h00;
        endcase
      end
      PH_PTR: begin
        case (st)
          4'd0: return 8'h6B;
          4'd1: return a[7:0];
          4'd2: return a[15:8];
          4'd3: return a[23:16];
          4'd4: return a[31:24];
          4'd5: return 8'hA0;
          4'd6: return len - 8'd1;
          default: return (k == RK_READ) ? 8'h24 : 8'h64;
        endcase
      end
      PH_DIRW: begin
        case (st)
          4'd0: return 8'h4C;
          4'd1: return da[7:0];
          4'd2: return da[15:8];
          4'd3: return da[23:16];
          4'd4: return da[31:24];
          default: return dd;
        endcase
      end
      PH_XFER: return (k == RK_LOAD) ? hold : 8'h00;
      PH_CLOSE: return (st == 4'd0) ? 8'hC1 : 8'h00;
      default: return 8'h00;
    endcase
  endfunction

endpackage

// File: rtl/nvm_seq_tries.sv
module nvm_seq_tries #(
  parameter int LIMIT = 256
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clear,
  input  logic bump,
  output logic expire
);
  localparam int CW = $clog2(LIMIT + 1);
  logic [CW-1:0] cnt_q;

  assign expire = bump && (cnt_q == CW'(LIMIT - 1));

  always_ff @(posedge clk) begin
    if (!rst_n || clear) cnt_q <= '0;
    else if (bump) cnt_q <= cnt_q + CW'(1);
  end
endmodule

// File: rtl/nvm_seq_frame.sv
module nvm_seq_frame
  import nvm_seq_pkg::*;
(
  input  phase_e      phase,
  input  logic [3:0]  step,
  input  rkind_e      kind,
  input  logic [31:0] addr,
  input  logic [7:0]  len,
  input  logic [7:0]  reg_val,
  input  logic [31:0] dir_addr,
  input  logic [7:0]  dir_data,
  input  logic [7:0]  hold,
  output lop_e        op,
  output logic [7:0]  byte_o
);
  always_comb begin
    op     = frame_op(phase, step, kind);
    byte_o = frame_byte(phase, step, kind, addr, len, reg_val, dir_addr, dir_data, hold);
  end
endmodule

// File: rtl/nvm_seq.sv
module nvm_seq
  import nvm_seq_pkg::*;
#(
  parameter int OPEN_TRIES = 256,
  parameter int BUSY_TRIES = 40000,
  parameter int LEN_W      = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_valid,
  input  logic [2:0]       req_kind,
  input  logic [31:0]      req_addr,
  input  logic [LEN_W-1:0] req_len,
  input  logic             req_eeprom,
  input  logic [2:0]       req_fuse_idx,
  input  logic [7:0]       req_value,
  input  logic [7:0]       boot_base,
  output logic             busy,
  output logic             done,
  output logic [2:0]       err_code,
  output logic [LEN_W-1:0] xfer_cnt,
  input  logic [7:0]       wr_data,
  input  logic             wr_valid,
  output logic             wr_ready,
  output logic [7:0]       rd_data,
  output logic             rd_valid,
  output logic             lnk_req,
  output logic [1:0]       lnk_op,
  output logic [7:0]       lnk_byte,
  input  logic             lnk_done,
  input  logic [7:0]       lnk_rdata,
  input  logic             lnk_rerr
);
  phase_e            phase_q;
  logic [3:0]        step_q;
  rkind_e            kind_q;
  logic [31:0]       addr_q, dir_addr_q;
  logic [LEN_W-1:0]  len_q, xcnt_q;
  logic [7:0]        reg_val_q, dir_data_q, hold_q;
  logic              have_q;
  lop_e              op_w;

  // named internal events, observed by the checker
  logic accept, hs, rx_bad, arm_try, arm_ok, arm_miss, stat_try, stat_idle, stat_busy;
  logic arm_expire, busy_expire, xfer_last, instant, load_xfer;
  rkind_e req_k;

  assign req_k     = rkind_e'(req_kind);
  assign busy      = (phase_q != PH_IDLE);
  assign accept    = req_valid && !busy;
  assign instant   = (req_k == RK_NONE) ||
                     ((req_k == RK_READ || req_k == RK_LOAD) && req_len == '0);
  assign load_xfer = (phase_q == PH_XFER) && (kind_q == RK_LOAD);
  assign wr_ready  = load_xfer && !have_q;
  assign lnk_req   = busy && (!load_xfer || have_q);
  assign lnk_op    = op_w;
  assign hs        = lnk_req && lnk_done;
  assign rx_bad    = hs && (op_w == LOP_RECV) && lnk_rerr;
  assign arm_try   = hs && !lnk_rerr && phase_q == PH_ARM && step_q == 4'd1;
  assign arm_ok    = arm_try && lnk_rdata[1];
  assign arm_miss  = arm_try && !lnk_rdata[1];
  assign stat_try  = hs && !lnk_rerr && phase_q == PH_POLL && step_q == 4'd5;
  assign stat_idle = stat_try && !lnk_rdata[7];
  assign stat_busy = stat_try && lnk_rdata[7];
  assign xfer_last = (xcnt_q + LEN_W'(1)) == len_q;
  assign xfer_cnt  = xcnt_q;

  nvm_seq_frame u_frame (
    .phase(phase_q), .step(step_q), .kind(kind_q), .addr(addr_q),
    .len(8'(len_q)), .reg_val(reg_val_q), .dir_addr(dir_addr_q),
    .dir_data(dir_data_q), .hold(hold_q), .op(op_w), .byte_o(lnk_byte)
  );

  nvm_seq_tries #(.LIMIT(OPEN_TRIES)) u_arm_tries (
    .clk(clk), .rst_n(rst_n), .clear(accept), .bump(arm_miss), .expire(arm_expire)
  );

  nvm_seq_tries #(.LIMIT(BUSY_TRIES)) u_busy_tries (
    .clk(clk), .rst_n(rst_n), .clear(accept), .bump(stat_busy), .expire(busy_expire)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      phase_q <= PH_IDLE;   step_q <= '0;      kind_q <= RK_NONE;
      addr_q <= '0;         dir_addr_q <= '0;  len_q <= '0;
      xcnt_q <= '0;         reg_val_q <= '0;   dir_data_q <= '0;
      hold_q <= '0;         have_q <= 1'b0;    done <= 1'b0;
      err_code <= ERR_NONE; rd_valid <= 1'b0;  rd_data <= '0;
    end else begin
      done     <= 1'b0;
      rd_valid <= 1'b0;
      if (accept) begin
        kind_q     <= req_k;
        addr_q     <= req_addr;
        len_q      <= req_len;
        xcnt_q     <= '0;
        err_code   <= ERR_NONE;
        have_q     <= 1'b0;
        step_q     <= '0;
        dir_addr_q <= (req_k == RK_FUSE) ? {24'h008F00, 5'b00100, req_fuse_idx} : req_addr;
        dir_data_q <= (req_k == RK_FUSE) ? req_value : 8'h00;
        case (req_k)
          RK_READ:   reg_val_q <= 8'h43;
          RK_LOAD:   reg_val_q <= load_cmd(req_eeprom);
          RK_COMMIT: reg_val_q <= commit_cmd(req_eeprom, req_addr, boot_base);
          RK_FUSE:   reg_val_q <= 8'h4C;
          default:   reg_val_q <= 8'h00;
        endcase
        if (instant) done <= 1'b1;
        else phase_q <= first_phase(req_k);
      end else if (busy) begin
        if (wr_ready && wr_valid) begin
          hold_q <= wr_data;
          have_q <= 1'b1;
        end
        if (hs) begin
          if (rx_bad) begin
            phase_q <= PH_IDLE; done <= 1'b1; err_code <= ERR_LINK;
          end else if (arm_ok || stat_idle) begin
            phase_q <= PH_IDLE; done <= 1'b1;
          end else if (arm_miss || stat_busy) begin
            if (arm_expire || busy_expire) begin
              phase_q  <= PH_IDLE;
              done     <= 1'b1;
              err_code <= arm_expire ? ERR_TIMEOUT : ERR_BUSY;
            end else begin
              step_q <= '0;
            end
          end else if (phase_q == PH_XFER) begin
            xcnt_q <= xcnt_q + LEN_W'(1);
            have_q <= 1'b0;
            if (kind_q == RK_READ) begin
              rd_valid <= 1'b1;
              rd_data  <= lnk_rdata;
            end
            if (xfer_last) begin
              phase_q <= PH_IDLE; done <= 1'b1;
            end
          end else if (step_q == phase_last(phase_q)) begin
            step_q  <= '0;
            phase_q <= next_phase(kind_q, phase_q);
            if (next_phase(kind_q, phase_q) == PH_IDLE) done <= 1'b1;
          end else begin
            step_q <= step_q + 4'd1;
          end
        end
      end
    end
  end
endmodule

// File: rtl/nvm_seq_chk.sv
module nvm_seq_chk #(
  parameter int LEN_W = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic             req_valid,
  input logic [2:0]       req_kind,
  input logic [LEN_W-1:0] req_len,
  input logic             busy,
  input logic             done,
  input logic [2:0]       err_code,
  input logic             wr_ready,
  input logic             rd_valid,
  input logic             lnk_req,
  input logic [1:0]       lnk_op,
  input logic [7:0]       lnk_byte,
  input logic             lnk_done,
  input logic             arm_expire,
  input logic             busy_expire
);
  p_idle_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (!lnk_req && !wr_ready));

  p_op_hold_r14: assert property (@(posedge clk) disable iff (!rst_n)
    (lnk_req && !lnk_done) |=> (lnk_req && $stable(lnk_op) && $stable(lnk_byte)));

  p_open_timeout_r3: assert property (@(posedge clk) disable iff (!rst_n)
    arm_expire |=> (done && err_code == 3'd2));

  p_busy_timeout_r10: assert property (@(posedge clk) disable iff (!rst_n)
    busy_expire |=> (done && err_code == 3'd5));

  p_rd_from_recv_r5: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid |-> ($past(lnk_done) && $past(lnk_op) == 2'd1));

  p_zero_len_r13: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !busy && (req_kind == 3'd1 || req_kind == 3'd2) && req_len == '0)
      |=> (done && !busy && err_code == 3'd0));

  // R6: only none, link, timeout and busy codes are produced
  p_err_set_r6: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (err_code == 3'd0 || err_code == 3'd1 || err_code == 3'd2 || err_code == 3'd5));
endmodule

bind nvm_seq nvm_seq_chk #(.LEN_W(LEN_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_kind(req_kind),
  .req_len(req_len), .busy(busy), .done(done), .err_code(err_code),
  .wr_ready(wr_ready), .rd_valid(rd_valid), .lnk_req(lnk_req), .lnk_op(lnk_op),
  .lnk_byte(lnk_byte), .lnk_done(lnk_done), .arm_expire(arm_expire),
  .busy_expire(busy_expire)
);

// File: tb/nvm_seq_bench.sv
module nvm_seq_bench;
  localparam int OT = 4;
  localparam int BT = 5;

  logic clk = 1'b0, rst_n = 1'b0;
  always #2.5 clk = ~clk;

  logic        req_valid = 1'b0, req_eeprom = 1'b0, wr_valid = 1'b1;
  logic [2:0]  req_kind = 3'd7, req_fuse_idx = 3'd0, err_code;
  logic [31:0] req_addr = '0;
  logic [7:0]  req_len = '0, req_value = '0, boot_base = 8'h82, xfer_cnt;
  logic [7:0]  wr_data, rd_data, lnk_byte, lnk_rdata = '0;
  logic        busy, done, wr_ready, rd_valid, lnk_req, lnk_done = 1'b0, lnk_rerr = 1'b0;
  logic [1:0]  lnk_op;

  nvm_seq #(.OPEN_TRIES(OT), .BUSY_TRIES(BT)) u_nvm_seq (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_kind(req_kind),
    .req_addr(req_addr), .req_len(req_len), .req_eeprom(req_eeprom),
    .req_fuse_idx(req_fuse_idx), .req_value(req_value), .boot_base(boot_base),
    .busy(busy), .done(done), .err_code(err_code), .xfer_cnt(xfer_cnt),
    .wr_data(wr_data), .wr_valid(wr_valid), .wr_ready(wr_ready),
    .rd_data(rd_data), .rd_valid(rd_valid), .lnk_req(lnk_req), .lnk_op(lnk_op),
    .lnk_byte(lnk_byte), .lnk_done(lnk_done), .lnk_rdata(lnk_rdata), .lnk_rerr(lnk_rerr)
  );

  int n_tests = 0, n_fail = 0;
  logic [9:0] log_v [0:1023];
  int log_n = 0;
  logic [7:0] rx_d [0:255];
  logic       rx_e [0:255];
  int rx_i = 0;
  logic [7:0] pay [0:63];
  int wr_i = 0;
  logic [7:0] got [0:63];
  int got_n = 0;
  logic [9:0] exp_v [0:255];
  int exp_n = 0;

  assign wr_data = pay[wr_i % 64];

  // link model: answers each requested operation one cycle later
  always @(posedge clk) begin
    lnk_done <= 1'b0;
    if (rst_n && lnk_req && !lnk_done) begin
      lnk_done <= 1'b1;
      log_v[log_n % 1024] <= {lnk_op, (lnk_op == 2'd0) ? lnk_byte : 8'h00};
      log_n <= log_n + 1;
      if (lnk_op == 2'd1) begin
        lnk_rdata <= rx_d[rx_i % 256];
        lnk_rerr  <= rx_e[rx_i % 256];
        rx_i <= rx_i + 1;
      end else begin
        lnk_rerr <= 1'b0;
      end
    end
  end

  always @(posedge clk) if (wr_valid && wr_ready) wr_i <= wr_i + 1;
  always @(posedge clk) if (rd_valid) begin
    got[got_n % 64] <= rd_data;
    got_n <= got_n + 1;
  end

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  task automatic es(input logic [7:0] b); exp_v[exp_n] = {2'd0, b}; exp_n++; endtask
  task automatic eo(input logic [1:0] o); exp_v[exp_n] = {o, 8'h00}; exp_n++; endtask
  task automatic e_regw(input logic [7:0] v);
    es(8'h4C); es(8'hCA); es(8'h01); es(8'h00); es(8'h01); es(v);
  endtask
  task automatic e_ptr(input logic [31:0] a, input logic [7:0] l, input logic [7:0] opc);
    es(8'h6B); es(a[7:0]); es(a[15:8]); es(a[23:16]); es(a[31:24]);
    es(8'hA0); es(l - 8'd1); es(opc);
  endtask
  task automatic e_poll;
    es(8'h0C); es(8'hCF); es(8'h01); es(8'h00); es(8'h01); eo(2'd1);
  endtask
  task automatic e_open_head;
    eo(2'd2);
    es(8'hC1); es(8'h59); es(8'hE0); es(8'hFF); es(8'h88); es(8'hD8);
    es(8'hCD); es(8'h45); es(8'hAB); es(8'h89); es(8'h12);
  endtask

  task automatic cmp_log(input string tag, input int lb);
    int bad = -1;
    chk(log_n - lb == exp_n, {tag, " op count"}, log_n - lb, exp_n);
    for (int i = 0; i < exp_n && i < log_n - lb; i++)
      if (bad < 0 && log_v[(lb + i) % 1024] != exp_v[i]) bad = i;
    if (bad >= 0) chk(1'b0, {tag, " op sequence"}, log_v[(lb + bad) % 1024], exp_v[bad]);
    else chk(1'b1, tag, 0, 0);
  endtask

  task automatic rx_set(input int k, input logic [7:0] d, input logic e);
    rx_d[(rx_i + k) % 256] = d;
    rx_e[(rx_i + k) % 256] = e;
  endtask

  task automatic run(input logic [2:0] k, input logic [31:0] a, input logic [7:0] l,
                     input logic ee, input logic [2:0] fi, input logic [7:0] fv, output int cyc);
    req_kind = k; req_addr = a; req_len = l; req_eeprom = ee;
    req_fuse_idx = fi; req_value = fv; req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    cyc = 1;
    while (!done) begin @(negedge clk); cyc++; end
    @(negedge clk);
  endtask

  task automatic t_reset;
    chk(!busy && !done && !lnk_req && !wr_ready && !rd_valid, "R1 idle outputs",
        {busy, done, lnk_req, wr_ready, rd_valid}, 0);
    chk(err_code == 0 && xfer_cnt == 0, "R1 err and count", {err_code, xfer_cnt}, 0);
  endtask

  task automatic t_open_ok;
    int lb = log_n, c;
    rx_set(0, 8'h00, 0); rx_set(1, 8'hFD, 0); rx_set(2, 8'h02, 0);
    exp_n = 0; e_open_head;
    for (int i = 0; i < 3; i++) begin es(8'h80); eo(2'd1); end
    run(3'd0, 0, 0, 0, 0, 0, c);
    cmp_log("R2 open frames", lb);
    chk(err_code == 0, "R2 open err", err_code, 0);
  endtask

  task automatic t_open_timeout;
    int lb = log_n, c;
    for (int i = 0; i < 8; i++) rx_set(i, 8'hFD, 0);
    exp_n = 0; e_open_head;
    for (int i = 0; i < OT; i++) begin es(8'h80); eo(2'd1); end
    run(3'd0, 0, 0, 0, 0, 0, c);
    cmp_log("R3 open attempts", lb);
    chk(err_code == 2, "R3 timeout code", err_code, 2);
  endtask

  task automatic t_read;
    int lb = log_n, gb = got_n, c;
    rx_set(0, 8'h1E, 0); rx_set(1, 8'h97, 0); rx_set(2, 8'h4C, 0);
    exp_n = 0; e_regw(8'h43); e_ptr(32'h01000090, 8'd3, 8'h24);
    for (int i = 0; i < 3; i++) eo(2'd1);
    run(3'd1, 32'h01000090, 8'd3, 0, 0, 0, c);
    cmp_log("R4 R5 read frames", lb);
    chk(got_n - gb == 3, "R5 read stream length", got_n - gb, 3);
    chk({got[gb % 64], got[(gb + 1) % 64], got[(gb + 2) % 64]} == 24'h1E974C,
        "R5 read stream data", {got[gb % 64], got[(gb + 1) % 64], got[(gb + 2) % 64]}, 24'h1E974C);
    chk(err_code == 0 && xfer_cnt == 3, "R5 read result", {err_code, xfer_cnt}, {3'd0, 8'd3});
  endtask

  task automatic t_read_err;
    int lb = log_n, gb = got_n, c;
    rx_set(0, 8'h11, 0); rx_set(1, 8'h22, 1); rx_set(2, 8'h33, 0);
    exp_n = 0; e_regw(8'h43); e_ptr(32'h00800010, 8'd4, 8'h24);
    eo(2'd1); eo(2'd1);
    run(3'd1, 32'h00800010, 8'd4, 0, 0, 0, c);
    cmp_log("R6 read stops early", lb);
    chk(err_code == 1, "R6 link error code", err_code, 1);
    chk(xfer_cnt == 1 && got_n - gb == 1, "R6 partial count", {xfer_cnt, 8'(got_n - gb)}, 16'h0101);
  endtask

  task automatic t_load(input logic ee, input logic [31:0] a, input logic [7:0] l);
    int lb = log_n, c;
    for (int i = 0; i < l; i++) pay[(wr_i + i) % 64] = 8'hA5 ^ 8'(i * 29);
    exp_n = 0; e_regw(ee ? 8'h33 : 8'h23); e_ptr(a, l, 8'h64);
    for (int i = 0; i < l; i++) es(8'hA5 ^ 8'(i * 29));
    run(3'd2, a, l, ee, 0, 0, c);
    cmp_log(ee ? "R7 eeprom load" : "R7 flash load", lb);
    chk(err_code == 0 && xfer_cnt == l, "R7 load result", {err_code, xfer_cnt}, {3'd0, l});
  endtask

  task automatic t_commit(input logic ee, input logic [31:0] a, input logic [7:0] cmd,
                          input int nbusy, input string tag);
    int lb = log_n, c, polls;
    polls = (nbusy >= BT) ? BT : nbusy + 1;
    for (int i = 0; i < polls; i++) rx_set(i, (i < nbusy) ? 8'h80 : 8'h7F, 0);
    exp_n = 0; e_regw(cmd);
    es(8'h4C); es(a[7:0]); es(a[15:8]); es(a[23:16]); es(a[31:24]); es(8'h00);
    for (int i = 0; i < polls; i++) e_poll;
    run(3'd3, a, 0, ee, 0, 0, c);
    cmp_log(tag, lb);
    if (nbusy >= BT) chk(err_code == 5, "R10 busy code", err_code, 5);
    else chk(err_code == 0, "R9 commit err", err_code, 0);
  endtask

  task automatic t_fuse;
    int lb = log_n, c;
    rx_set(0, 8'h00, 0);
    exp_n = 0; e_regw(8'h4C);
    es(8'h4C); es(8'h23); es(8'h00); es(8'h8F); es(8'h00); es(8'hA5); e_poll;
    run(3'd4, 0, 0, 0, 3'd3, 8'hA5, c);
    cmp_log("R11 fuse frames", lb);
    chk(err_code == 0, "R11 fuse err", err_code, 0);
  endtask

  task automatic t_poll_ignore;
    int lb = log_n;
    rx_set(0, 8'h80, 0); rx_set(1, 8'h00, 0);
    exp_n = 0; e_poll; e_poll;
    req_kind = 3'd5; req_valid = 1'b1;
    @(negedge clk); req_valid = 1'b0;
    repeat (3) @(negedge clk);
    req_kind = 3'd6; req_valid = 1'b1;
    @(negedge clk); req_valid = 1'b0;
    while (!done) @(negedge clk);
    repeat (6) @(negedge clk);
    cmp_log("R9 R14 poll, request during busy ignored", lb);
    chk(!busy && err_code == 0, "R14 idle after poll", {busy, err_code}, 0);
  endtask

  task automatic t_close;
    int lb = log_n, c;
    exp_n = 0; es(8'hC1); es(8'h00); e_regw(8'h00); eo(2'd3);
    run(3'd6, 0, 0, 0, 0, 0, c);
    cmp_log("R12 close frames", lb);
  endtask

  task automatic t_zero(input logic [2:0] k, input string tag);
    int lb = log_n, c;
    run(k, 32'h00800000, 8'd0, 0, 0, 0, c);
    chk(c == 1, {tag, " done latency"}, c, 1);
    chk(log_n == lb && xfer_cnt == 0 && err_code == 0, {tag, " no traffic"},
        {8'(log_n - lb), xfer_cnt, 5'd0, err_code}, 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog act=running exp=finished");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    for (int i = 0; i < 256; i++) begin rx_d[i] = 8'h00; rx_e[i] = 1'b0; end
    for (int i = 0; i < 64; i++) pay[i] = 8'h00;
    repeat (4) @(negedge clk);
    t_reset;
    rst_n = 1'b1;
    @(negedge clk);
    t_reset;
    t_open_ok;
    t_open_timeout;
    t_read;
    t_zero(3'd1, "R13 zero read");
    t_read_err;
    t_load(1'b0, 32'h00800200, 8'd2);
    t_load(1'b1, 32'h008C0020, 8'd1);
    t_zero(3'd2, "R13 zero load");
    t_zero(3'd7, "R13 kind 7");
    t_commit(1'b0, 32'h00810000, 8'h25, 2, "R8 R9 flash below boot base");
    t_commit(1'b0, 32'h00820000, 8'h2D, 0, "R8 flash at boot base");
    t_commit(1'b1, 32'h008C0040, 8'h35, 1, "R8 eeprom commit");
    t_commit(1'b0, 32'h00800400, 8'h25, BT + 3, "R10 busy polls");
    t_fuse;
    t_poll_ignore;
    t_close;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule